// File: doc/BRIEF.md
# Grouped Event Selection Matrix

This block sits in front of a bank of event counters and turns a wide field of raw event strobes into one increment pulse per counter per cycle. The strobes form a matrix of event groups (columns) and event codes (rows). A shared 64-bit selection register picks one code for every group. Each counter then chooses only a group, and inherits whatever code that group currently selects. Two counters therefore can never count two different codes of the same group.

Each group's selected strobe travels with two qualifiers: a sub-unit index and an origin class. Every counter has its own filter register. An event reaches the counter only when the filter admits both its sub-unit and its origin. A global enable bit in the selection register gates the whole matrix. Configuration arrives through a single write port. One write form takes a packed 12-bit event identifier, and in the same cycle it programs the group's code field and the counter's group. The cycle-count identifier is left to a separate cycle counter and does not touch the matrix.

Top module: `evsel_matrix`

## Requirements
- R1: After a synchronous reset, `resource_o` is all zeros and `inc_o` is zero.
- R2: A write with kind 0 (event identifier) takes the group from `cfg_wdata_i[3:0]` and the code from `cfg_wdata_i[11:4]`. It stores the code in bits [8g+7:8g] of `resource_o` for group g. In the same cycle it sets the group of counter `cfg_idx_i` to g.
- R3: An identifier write changes only its own group's field. The other seven fields and the enable bit keep their values. Without a write, `resource_o` does not change.
- R4: An identifier write with identifier 0x0FE (the cycle event), or with a group field above 7, changes neither `resource_o` nor any counter's group.
- R5: A write with kind 1 sets the enable bit `resource_o[63]` to `cfg_wdata_i[0]` and leaves all other bits unchanged. While the enable bit is 0, no increment pulses are produced.
- R6: Bit 63 is shared between the enable and the top bit of group 7's field. An identifier write for group 7 updates only bits [62:56]. Group 7 selects the code {0, bits[62:56]}.
- R7: A write with kind 2 sets the group of counter `cfg_idx_i` to `cfg_wdata_i[3:0]`. A counter whose group is above 7 never pulses.
- R8: Counters that name the same group, and have equal filters, receive identical pulse streams.
- R9: A write with kind 3 stores `cfg_wdata_i & 0x000E0007` as the filter of counter `cfg_idx_i`. A pulse passes only when two filter bits are both set: bit 17+sub for the group's 2-bit sub-unit qualifier, and bit org for its 2-bit origin qualifier (0 and 1 are origin classes, 2 is ID-independent). Qualifier value 3 never passes.
- R10: A strobe presented in the cycle before clock edge n appears on `inc_o` after edge n+1. Each strobe cycle gives a one-cycle pulse.
- R11: A counter pulses only for the strobe at index g*256+code of `raw_evt_i`, where code is the code currently selected for its group g. Strobes at any other code of that group, or in any other group, have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_kind_i | input | 2 | Write kind: 0 identifier, 1 enable, 2 group, 3 filter |
| cfg_idx_i | input | 2 | Target counter |
| cfg_wdata_i | input | 32 | Write data |
| raw_evt_i | input | 2048 | Raw strobes, index group*256+code |
| grp_sub_i | input | 16 | 2-bit sub-unit qualifier per group |
| grp_org_i | input | 16 | 2-bit origin qualifier per group |
| resource_o | output | 64 | Shared code-selection register with enable in bit 63 |
| inc_o | output | 4 | Increment pulse per counter |

## Verification
The bench aims at the shared bit 63. A design that wrote a group 7 code straight across the field would switch the matrix off or on as a side effect, and would select the wrong row. It also sends the reserved cycle identifier and an out-of-range group through the identifier path: a design that decoded either one would corrupt a field or retarget a counter, which shows up as lost pulses on a counter that was already counting. It walks each filter qualifier, including the value 3 that has no bit, so that a design with swapped or unmasked filter fields passes events it should block. Counters that share a group are compared, and the two-edge latency is checked cycle by cycle, so a design that drops or adds a register stage is caught.

// File: rtl/evsel_pkg.sv
package evsel_pkg;
  localparam int RES_W   = 64;
  localparam int EN_BIT  = RES_W - 1;
  localparam int FILT_W  = 32;
  localparam int SUB_LSB = 17;
  localparam int ORG_LSB = 0;
  localparam logic [FILT_W-1:0] FILT_KEEP = 32'h000E_0007;
  localparam logic [11:0] CYCLE_EVT_ID = 12'h0FE;

  typedef enum logic [1:0] {
    CFG_EVT_ID = 2'd0,
    CFG_ENABLE = 2'd1,
    CFG_TYPE   = 2'd2,
    CFG_FILTER = 2'd3
  } cfg_kind_e;
endpackage

// File: rtl/evsel_resource.sv
module evsel_resource
  import evsel_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int CODE_W     = 8,
  parameter int GRP_W      = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         id_wr,
  input  logic                         en_wr,
  input  logic [GRP_W-1:0]             wr_grp,
  input  logic [CODE_W-1:0]            wr_code,
  input  logic                         en_val,
  output logic [RES_W-1:0]             res_o,
  output logic [NUM_GROUPS*CODE_W-1:0] code_flat_o,
  output logic                         en_o
);
  localparam logic [RES_W-1:0] EN_MASK   = {1'b1, {(RES_W-1){1'b0}}};
  localparam logic [RES_W-1:0] FIELD_ONE = {{(RES_W-CODE_W){1'b0}}, {CODE_W{1'b1}}};

  logic [RES_W-1:0] res_q;
  logic [RES_W-1:0] fmask;
  logic [RES_W-1:0] fval;

  always_comb begin
    fmask = (FIELD_ONE << (int'(wr_grp) * CODE_W)) & ~EN_MASK;
    fval  = {{(RES_W-CODE_W){1'b0}}, wr_code} << (int'(wr_grp) * CODE_W);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
    end else if (id_wr) begin
      res_q <= (res_q & ~fmask) | (fval & fmask);
    end else if (en_wr) begin
      res_q[EN_BIT] <= en_val;
    end
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_code
    assign code_flat_o[g*CODE_W +: CODE_W] =
      res_q[g*CODE_W +: CODE_W] & ~EN_MASK[g*CODE_W +: CODE_W];
  end

  assign res_o = res_q;
  assign en_o  = res_q[EN_BIT];
endmodule

// File: rtl/evsel_group_sel.sv
module evsel_group_sel #(
  parameter int NUM_GROUPS = 8,
  parameter int CODE_W     = 8,
  parameter int QUAL_W     = 2,
  localparam int CODES     = 1 << CODE_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         en,
  input  logic [NUM_GROUPS*CODES-1:0]  raw_evt,
  input  logic [NUM_GROUPS*CODE_W-1:0] code_flat,
  input  logic [NUM_GROUPS*QUAL_W-1:0] sub_in,
  input  logic [NUM_GROUPS*QUAL_W-1:0] org_in,
  output logic [NUM_GROUPS-1:0]        sel_q,
  output logic [NUM_GROUPS*QUAL_W-1:0] sub_q,
  output logic [NUM_GROUPS*QUAL_W-1:0] org_q
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_col
    logic [CODES-1:0]  column;
    logic [CODE_W-1:0] pick;
    logic              hit_r;
    logic [QUAL_W-1:0] sub_r;
    logic [QUAL_W-1:0] org_r;

    assign column = raw_evt[g*CODES +: CODES];
    assign pick   = code_flat[g*CODE_W +: CODE_W];

    always_ff @(posedge clk) begin
      if (rst) begin
        hit_r <= 1'b0;
        sub_r <= '0;
        org_r <= '0;
      end else begin
        hit_r <= en & column[pick];
        sub_r <= sub_in[g*QUAL_W +: QUAL_W];
        org_r <= org_in[g*QUAL_W +: QUAL_W];
      end
    end

    assign sel_q[g]                 = hit_r;
    assign sub_q[g*QUAL_W +: QUAL_W] = sub_r;
    assign org_q[g*QUAL_W +: QUAL_W] = org_r;
  end
endmodule

// File: rtl/evsel_ctr_route.sv
module evsel_ctr_route
  import evsel_pkg::*;
#(
  parameter int NUM_CTRS  = 4,
  parameter int GRP_W     = 4,
  parameter int QUAL_W    = 2,
  parameter int CTR_IDX_W = 2,
  localparam int GRP_SPACE = 1 << GRP_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_we,
  input  logic [1:0]                    cfg_kind,
  input  logic [CTR_IDX_W-1:0]          cfg_idx,
  input  logic [FILT_W-1:0]             cfg_wdata,
  input  logic                          id_ok,
  input  logic [GRP_SPACE-1:0]          sel_pad,
  input  logic [GRP_SPACE*QUAL_W-1:0]   sub_pad,
  input  logic [GRP_SPACE*QUAL_W-1:0]   org_pad,
  output logic [NUM_CTRS-1:0]           inc_o,
  output logic [NUM_CTRS*GRP_W-1:0]     type_flat_o,
  output logic [NUM_CTRS*FILT_W-1:0]    filt_flat_o
);
  for (genvar c = 0; c < NUM_CTRS; c++) begin : g_ctr
    logic [GRP_W-1:0]            type_q;
    logic [FILT_W-1:0]           filt_q;
    logic                        inc_r;
    logic                        hit;
    logic [GRP_SPACE*QUAL_W-1:0] sub_sh;
    logic [GRP_SPACE*QUAL_W-1:0] org_sh;
    logic [FILT_W-1:0]           sub_bit;
    logic [FILT_W-1:0]           org_bit;
    logic                        pass;
    logic                        mine;

    assign mine = cfg_we && (cfg_idx == CTR_IDX_W'(c));

    always_ff @(posedge clk) begin
      if (rst) begin
        type_q <= '0;
        filt_q <= '0;
      end else if (mine) begin
        if (cfg_kind == CFG_EVT_ID && id_ok) type_q <= cfg_wdata[GRP_W-1:0];
        if (cfg_kind == CFG_TYPE)            type_q <= cfg_wdata[GRP_W-1:0];
        if (cfg_kind == CFG_FILTER)          filt_q <= cfg_wdata & FILT_KEEP;
      end
    end

    always_comb begin
      hit     = sel_pad[type_q];
      sub_sh  = sub_pad >> (int'(type_q) * QUAL_W);
      org_sh  = org_pad >> (int'(type_q) * QUAL_W);
      sub_bit = {{(FILT_W-1){1'b0}}, 1'b1} << (SUB_LSB + int'(sub_sh[QUAL_W-1:0]));
      org_bit = {{(FILT_W-1){1'b0}}, 1'b1} << (ORG_LSB + int'(org_sh[QUAL_W-1:0]));
      pass    = (|(filt_q & sub_bit)) && (|(filt_q & org_bit));
    end

    always_ff @(posedge clk) begin
      if (rst) inc_r <= 1'b0;
      else     inc_r <= hit && pass;
    end

    assign inc_o[c]                        = inc_r;
    assign type_flat_o[c*GRP_W +: GRP_W]   = type_q;
    assign filt_flat_o[c*FILT_W +: FILT_W] = filt_q;
  end
endmodule

// File: rtl/evsel_matrix.sv
module evsel_matrix
  import evsel_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int CODE_W     = 8,
  parameter int GRP_W      = 4,
  parameter int QUAL_W     = 2,
  parameter int NUM_CTRS   = 4,
  localparam int CODES     = 1 << CODE_W,
  localparam int ID_W      = GRP_W + CODE_W,
  localparam int GRP_SPACE = 1 << GRP_W,
  localparam int CTR_IDX_W = (NUM_CTRS > 1) ? $clog2(NUM_CTRS) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cfg_we_i,
  input  logic [1:0]                   cfg_kind_i,
  input  logic [CTR_IDX_W-1:0]         cfg_idx_i,
  input  logic [FILT_W-1:0]            cfg_wdata_i,
  input  logic [NUM_GROUPS*CODES-1:0]  raw_evt_i,
  input  logic [NUM_GROUPS*QUAL_W-1:0] grp_sub_i,
  input  logic [NUM_GROUPS*QUAL_W-1:0] grp_org_i,
  output logic [RES_W-1:0]             resource_o,
  output logic [NUM_CTRS-1:0]          inc_o
);
  logic [ID_W-1:0]              evt_id;
  logic [GRP_W-1:0]             evt_grp;
  logic                         id_ok;
  logic                         id_wr;
  logic                         en_wr;
  logic [NUM_GROUPS*CODE_W-1:0] code_flat;
  logic                         mat_en;
  logic [NUM_GROUPS-1:0]        sel_q;
  logic [NUM_GROUPS*QUAL_W-1:0] sub_q;
  logic [NUM_GROUPS*QUAL_W-1:0] org_q;
  logic [GRP_SPACE-1:0]         sel_pad;
  logic [GRP_SPACE*QUAL_W-1:0]  sub_pad;
  logic [GRP_SPACE*QUAL_W-1:0]  org_pad;
  logic [NUM_CTRS*GRP_W-1:0]    type_flat;
  logic [NUM_CTRS*FILT_W-1:0]   filt_flat;

  assign evt_id  = cfg_wdata_i[ID_W-1:0];
  assign evt_grp = evt_id[GRP_W-1:0];
  assign id_ok   = (int'(evt_grp) < NUM_GROUPS) && (evt_id != ID_W'(CYCLE_EVT_ID));
  assign id_wr   = cfg_we_i && (cfg_kind_i == CFG_EVT_ID) && id_ok;
  assign en_wr   = cfg_we_i && (cfg_kind_i == CFG_ENABLE);

  evsel_resource #(
    .NUM_GROUPS(NUM_GROUPS), .CODE_W(CODE_W), .GRP_W(GRP_W)
  ) u_res (
    .clk(clk), .rst(rst), .id_wr(id_wr), .en_wr(en_wr),
    .wr_grp(evt_grp), .wr_code(evt_id[ID_W-1:GRP_W]), .en_val(cfg_wdata_i[0]),
    .res_o(resource_o), .code_flat_o(code_flat), .en_o(mat_en)
  );

  evsel_group_sel #(
    .NUM_GROUPS(NUM_GROUPS), .CODE_W(CODE_W), .QUAL_W(QUAL_W)
  ) u_sel (
    .clk(clk), .rst(rst), .en(mat_en), .raw_evt(raw_evt_i), .code_flat(code_flat),
    .sub_in(grp_sub_i), .org_in(grp_org_i),
    .sel_q(sel_q), .sub_q(sub_q), .org_q(org_q)
  );

  assign sel_pad = {{(GRP_SPACE-NUM_GROUPS){1'b0}}, sel_q};
  assign sub_pad = {{((GRP_SPACE-NUM_GROUPS)*QUAL_W){1'b0}}, sub_q};
  assign org_pad = {{((GRP_SPACE-NUM_GROUPS)*QUAL_W){1'b0}}, org_q};

  evsel_ctr_route #(
    .NUM_CTRS(NUM_CTRS), .GRP_W(GRP_W), .QUAL_W(QUAL_W), .CTR_IDX_W(CTR_IDX_W)
  ) u_route (
    .clk(clk), .rst(rst), .cfg_we(cfg_we_i), .cfg_kind(cfg_kind_i), .cfg_idx(cfg_idx_i),
    .cfg_wdata(cfg_wdata_i), .id_ok(id_ok),
    .sel_pad(sel_pad), .sub_pad(sub_pad), .org_pad(org_pad),
    .inc_o(inc_o), .type_flat_o(type_flat), .filt_flat_o(filt_flat)
  );
endmodule

// File: rtl/evsel_matrix_chk.sv
module evsel_matrix_chk
  import evsel_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int CODE_W     = 8,
  parameter int GRP_W      = 4,
  parameter int NUM_CTRS   = 4,
  localparam int ID_W      = GRP_W + CODE_W
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        cfg_we,
  input logic [1:0]                  cfg_kind,
  input logic [ID_W-1:0]             cfg_id,
  input logic [RES_W-1:0]            resource,
  input logic [NUM_CTRS-1:0]         inc,
  input logic [NUM_CTRS*GRP_W-1:0]   type_flat,
  input logic [NUM_CTRS*FILT_W-1:0]  filt_flat
);
  localparam logic [RES_W-1:0] EN_MASK   = {1'b1, {(RES_W-1){1'b0}}};
  localparam logic [RES_W-1:0] FIELD_ONE = {{(RES_W-CODE_W){1'b0}}, {CODE_W{1'b1}}};

  logic [RES_W-1:0] keep_mask;
  assign keep_mask = ~(FIELD_ONE << (int'(cfg_id[GRP_W-1:0]) * CODE_W)) | EN_MASK;

  // R3
  other_fields_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_kind == CFG_EVT_ID) |=>
      (((resource ^ $past(resource)) & $past(keep_mask)) == '0));

  // R3
  idle_resource_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(resource));

  // R4
  cycle_id_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_kind == CFG_EVT_ID && cfg_id == ID_W'(CYCLE_EVT_ID)) |=> $stable(resource));

  // R5
  disabled_no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(resource[EN_BIT], 2) |-> (inc == '0));

  for (genvar c = 0; c < NUM_CTRS; c++) begin : g_chk
    // R7
    group_range_chk: assert property (@(posedge clk) disable iff (rst)
      (int'($past(type_flat[c*GRP_W +: GRP_W])) >= NUM_GROUPS) |-> !inc[c]);

    // R9
    empty_filter_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(filt_flat[c*FILT_W +: FILT_W]) == '0) |-> !inc[c]);

    if (c > 0) begin : g_pair
      // R8
      shared_group_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(type_flat[c*GRP_W +: GRP_W]) == $past(type_flat[0 +: GRP_W])) &&
         ($past(filt_flat[c*FILT_W +: FILT_W]) == $past(filt_flat[0 +: FILT_W])))
          |-> (inc[c] == inc[0]));
    end
  end
endmodule

bind evsel_matrix evsel_matrix_chk #(
  .NUM_GROUPS(NUM_GROUPS), .CODE_W(CODE_W), .GRP_W(GRP_W), .NUM_CTRS(NUM_CTRS)
) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we_i), .cfg_kind(cfg_kind_i),
  .cfg_id(cfg_wdata_i[GRP_W+CODE_W-1:0]), .resource(resource_o), .inc(inc_o),
  .type_flat(type_flat), .filt_flat(filt_flat)
);

// File: tb/evsel_matrix_tb.sv
module evsel_matrix_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 8;
  localparam int CODES = 256;
  localparam int NC = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cfg_we = 1'b0;
  logic [1:0]      cfg_kind = 2'd0;
  logic [1:0]      cfg_idx = 2'd0;
  logic [31:0]     cfg_wdata = '0;
  logic [NG*CODES-1:0] raw = '0;
  logic [NG*2-1:0] gsub = '0;
  logic [NG*2-1:0] gorg = '0;
  logic [63:0]     res;
  logic [NC-1:0]   inc;

  int total = 0;
  int bad = 0;
  logic [63:0] exp_res = '0;
  logic finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evsel_matrix u_dut (
    .clk(clk), .rst(rst), .cfg_we_i(cfg_we), .cfg_kind_i(cfg_kind), .cfg_idx_i(cfg_idx),
    .cfg_wdata_i(cfg_wdata), .raw_evt_i(raw), .grp_sub_i(gsub), .grp_org_i(gorg),
    .resource_o(res), .inc_o(inc)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model_id(input logic [63:0] r, input logic [11:0] id);
    logic [63:0] n = r;
    int grp = int'(id[3:0]);
    if (id == 12'h0FE || grp > 7) return r;
    for (int b = 0; b < 8; b++) begin
      if (grp*8 + b != 63) n[grp*8 + b] = id[4 + b];
    end
    return n;
  endfunction

  task automatic cfg(input logic [1:0] kind, input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = kind; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (kind == 2'd0) exp_res = model_id(exp_res, d[11:0]);
    if (kind == 2'd1) exp_res[63] = d[0];
  endtask

  // presents one strobe cycle, checks latency, value and pulse width (R10)
  task automatic fire(input string req, input int g, input int code, input logic all,
                      input logic [1:0] sub, input logic [1:0] org, input logic [NC-1:0] exp);
    @(negedge clk);
    raw = '0;
    if (all) raw = '1;
    else raw[g*CODES + code] = 1'b1;
    gsub = {NG{sub}};
    gorg = {NG{org}};
    @(negedge clk);
    raw = '0;
    check("R10 latency", 64'(inc), 64'(0));
    @(negedge clk);
    check(req, 64'(inc), 64'(exp));
    @(negedge clk);
    check("R10 single pulse", 64'(inc), 64'(0));
  endtask

  task automatic t_reset();
    check("R1 resource", res, 64'h0);
    check("R1 inc", 64'(inc), 64'h0);
    fire("R1 no pulse", 0, 0, 1'b0, 2'd0, 2'd0, 4'b0000);
  endtask

  task automatic t_disabled();
    cfg(2'd0, 2'd0, 32'h052);
    cfg(2'd3, 2'd0, 32'h000E_0007);
    check("R2 field write", res, exp_res);
    check("R2 field value", res, 64'h0000_0000_0005_0000);
    fire("R5 disabled", 2, 5, 1'b0, 2'd0, 2'd0, 4'b0000);
  endtask

  task automatic t_basic();
    cfg(2'd1, 2'd0, 32'h1);
    check("R5 enable bit", res, exp_res);
    fire("R11 selected code", 2, 5, 1'b0, 2'd0, 2'd0, 4'b0001);
    fire("R11 other code", 2, 6, 1'b0, 2'd0, 2'd0, 4'b0000);
    fire("R11 other group", 3, 5, 1'b0, 2'd0, 2'd0, 4'b0000);
  endtask

  task automatic t_isolation();
    cfg(2'd0, 2'd1, 32'hAA3);
    check("R3 other fields kept", res, exp_res);
    check("R3 value", res, 64'h8000_0000_AA05_0000);
  endtask

  task automatic t_shared();
    cfg(2'd2, 2'd2, 32'h2);
    cfg(2'd3, 2'd2, 32'hFFFF_FFFF);
    fire("R8 shared group", 2, 5, 1'b0, 2'd0, 2'd0, 4'b0101);
    fire("R9 empty filter", 3, 8'hAA, 1'b0, 2'd0, 2'd0, 4'b0000);
  endtask

  task automatic t_range();
    cfg(2'd2, 2'd3, 32'h9);
    cfg(2'd3, 2'd3, 32'h000E_0007);
    fire("R7 group above 7", 0, 0, 1'b1, 2'd0, 2'd0, 4'b0101);
  endtask

  task automatic t_filter();
    cfg(2'd3, 2'd0, 32'h0002_0001);
    fire("R9 sub0 org0", 2, 5, 1'b0, 2'd0, 2'd0, 4'b0101);
    fire("R9 sub1 blocked", 2, 5, 1'b0, 2'd1, 2'd0, 4'b0100);
    fire("R9 org1 blocked", 2, 5, 1'b0, 2'd0, 2'd1, 4'b0100);
    fire("R9 id-indep blocked", 2, 5, 1'b0, 2'd0, 2'd2, 4'b0100);
    cfg(2'd3, 2'd0, 32'h0002_0004);
    fire("R9 id-indep passes", 2, 5, 1'b0, 2'd0, 2'd2, 4'b0101);
    fire("R9 org0 now blocked", 2, 5, 1'b0, 2'd0, 2'd0, 4'b0100);
    fire("R9 sub3 never", 2, 5, 1'b0, 2'd3, 2'd2, 4'b0000);
    fire("R9 org3 never", 2, 5, 1'b0, 2'd0, 2'd3, 4'b0000);
  endtask

  task automatic t_reserved();
    cfg(2'd0, 2'd0, 32'h0FE);
    check("R4 cycle id", res, 64'h8000_0000_AA05_0000);
    cfg(2'd0, 2'd0, 32'h0A9);
    check("R4 group 9", res, 64'h8000_0000_AA05_0000);
    fire("R4 counter kept", 2, 5, 1'b0, 2'd0, 2'd2, 4'b0101);
  endtask

  task automatic t_group7();
    cfg(2'd0, 2'd1, 32'h857);
    cfg(2'd3, 2'd1, 32'h000E_0007);
    check("R6 shared top bit", res, exp_res);
    check("R6 value", res, 64'h8500_0000_AA05_0000);
    fire("R6 group7 code5", 7, 5, 1'b0, 2'd0, 2'd0, 4'b0010);
    fire("R6 group7 code85", 7, 8'h85, 1'b0, 2'd0, 2'd0, 4'b0000);
  endtask

  task automatic t_disable();
    cfg(2'd1, 2'd0, 32'h0);
    check("R5 disable keeps fields", res, 64'h0500_0000_AA05_0000);
    fire("R5 disabled again", 2, 5, 1'b0, 2'd0, 2'd2, 4'b0000);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_basic();
    t_isolation();
    t_shared();
    t_range();
    t_filter();
    t_reserved();
    t_group7();
    t_disable();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*20000);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule